// File: doc/BRIEF.md
# Serial Synthesizer Channel Loader

This controller programs an external frequency synthesizer from a table of channel words kept in a read-only memory. When the user strobes `start` with a channel number and a receive/transmit selection, the block works out where that channel's entry sits in the table, fetches the entry one byte at a time, and sends it out on a three-wire serial link made of data, clock and load lines. Once all the bits are out, it pulses the load line so that the synthesizer latches its new divider word.

Every table entry is four bytes long. The block always sends all 32 bits, but the receiving shift register holds only 17. The first 15 bits therefore pass straight through the receiver and are lost, and the final 17 bits become the programmed word. The table keeps receive entries and transmit entries in two separate regions. The serial bit rate is set by a parameterised divider of the system clock.

Top module: `chanload_top`

## Requirements
- R1: A transfer for channel `c` reads ROM addresses `B + 4*c`, `B + 4*c + 1`, `B + 4*c + 2` and `B + 4*c + 3`, in that order. `B` is 0x000 when `tx_sel` is 0 and 0x400 when `tx_sel` is 1, so channel 1 starts at offset 4 of its region. The ROM returns data one clock after the address.
- R2: Each transfer produces exactly 32 rising edges of `ser_clk`. Byte 0 is sent first, and within each byte the most significant bit goes first.
- R3: `ser_data` changes only while `ser_clk` is low, and holds steady for the whole of every high phase, so the receiver samples it on the rising edge.
- R4: A 17-bit receiver that samples on rising edges ends the transfer holding the low 17 bits of the 32-bit entry. With the table holding bytes 00 01 1E 10 at 0x004 and 00 01 1B 18 at 0x404, channel 1 yields 0x11E10 for receive and 0x11B18 for transmit.
- R5: `ser_load` rises only after the 32nd rising edge, once `ser_clk` has fallen again. It stays high for exactly one bit period (2*HALF_DIV cycles), rises once per transfer, and `ser_clk` stays low while it is high.
- R6: `busy` goes high in the cycle after an accepted `start`. `done` is high for exactly one cycle, in the same cycle that `ser_load` falls, and `busy` is low in that cycle.
- R7: A `start` that arrives while `busy` is high is ignored. The transfer in progress finishes with its original channel and direction, and no second transfer follows.
- R8: Each high phase of `ser_clk` lasts exactly HALF_DIV system cycles.
- R9: After reset, `ser_clk`, `ser_data`, `ser_load`, `busy` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to begin a transfer |
| chan | input | 8 | Channel number |
| tx_sel | input | 1 | 1 selects the transmit region, 0 selects the receive region |
| rom_addr | output | 11 | Byte address to the table ROM |
| rom_data | input | 8 | ROM byte, valid one cycle after the address |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer completes |
| ser_data | output | 1 | Serial data to the synthesizer |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_load | output | 1 | Latch strobe to the synthesizer |

## Verification
The four ROM addresses appear one after another, each in the cycle the previous byte's last high phase ends, and the bench compares each one against a queued expectation as soon as it appears. Serial bits are due at every rising edge of `ser_clk`, so the monitor samples at the falling system-clock edge that follows each rising edge. It also times each high phase against HALF_DIV. The queued 32-bit entry and its 17-bit receiver image are compared when `ser_load` rises. The load width is counted until `ser_load` falls, and `done` and `busy` are checked in that same cycle.

// File: rtl/chanload_pkg.sv
package chanload_pkg;

    localparam int ADDR_W      = 11;
    localparam int CHAN_W      = 8;
    localparam int BYTE_W      = 8;
    localparam int ENTRY_BYTES = 4;
    localparam int IDX_W       = $clog2(ENTRY_BYTES);
    localparam int BIT_IDX_W   = $clog2(BYTE_W);
    localparam logic [ADDR_W-1:0] RX_BASE = 11'h000;
    localparam logic [ADDR_W-1:0] TX_BASE = 11'h400;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_GRAB,
        ST_LOW,
        ST_HIGH,
        ST_LOAD
    } ld_state_e;

    typedef struct packed {
        logic              clk;
        logic              load;
        logic              done;
    } ser_ctl_t;

    function automatic logic [ADDR_W-1:0] entry_addr(
        input logic [CHAN_W-1:0] chan,
        input logic              tx
    );
        logic [ADDR_W-1:0] base;
        base = tx ? TX_BASE : RX_BASE;
        return base + (ADDR_W'(chan) << IDX_W);
    endfunction

endpackage

// File: rtl/chanload_tick.sv
module chanload_tick #(
    parameter int HALF_DIV = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = $clog2(HALF_DIV) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == LAST);

    // R8: the divider count never passes its terminal value
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/chanload_shift.sv
module chanload_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [WIDTH-1:0] din,
    input  logic             shift,
    output logic             msb
);
    logic [WIDTH-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (ld) begin
            sr_q <= din;
        end else if (shift) begin
            sr_q <= {sr_q[WIDTH-2:0], 1'b0};
        end
    end

    assign msb = sr_q[WIDTH-1];

endmodule

// File: rtl/chanload_ctrl.sv
module chanload_ctrl
    import chanload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CHAN_W-1:0] chan,
    input  logic              tx_sel,
    input  logic              tick,
    output logic              tick_en,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              sh_ld,
    output logic              sh_shift,
    output logic              bit_phase,
    output logic              busy,
    output ser_ctl_t          ctl
);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT  = BIT_IDX_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0]     LAST_BYTE = IDX_W'(ENTRY_BYTES - 1);

    ld_state_e            state_q, state_n;
    logic [ADDR_W-1:0]    addr_q;
    logic [BIT_IDX_W-1:0] bit_q;
    logic [IDX_W-1:0]     byte_q;
    logic                 half_q;
    ser_ctl_t             ctl_q;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_n = ST_ADDR;
            ST_ADDR: state_n = ST_GRAB;
            ST_GRAB: state_n = ST_LOW;
            ST_LOW:  if (tick) state_n = ST_HIGH;
            ST_HIGH: if (tick) begin
                if (bit_q != LAST_BIT)       state_n = ST_LOW;
                else if (byte_q != LAST_BYTE) state_n = ST_ADDR;
                else                          state_n = ST_LOAD;
            end
            ST_LOAD: if (tick && half_q) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            bit_q   <= '0;
            byte_q  <= '0;
            half_q  <= 1'b0;
            ctl_q   <= '0;
        end else begin
            state_q    <= state_n;
            ctl_q.clk  <= (state_n == ST_HIGH);
            ctl_q.load <= (state_n == ST_LOAD);
            ctl_q.done <= (state_q == ST_LOAD) && (state_n == ST_IDLE);
            if (state_q == ST_IDLE && start) begin
                addr_q <= entry_addr(chan, tx_sel);
                bit_q  <= '0;
                byte_q <= '0;
            end
            if (state_q == ST_HIGH && tick) begin
                if (bit_q == LAST_BIT) begin
                    bit_q <= '0;
                    if (byte_q != LAST_BYTE) begin
                        byte_q <= byte_q + 1'b1;
                        addr_q <= addr_q + 1'b1;
                    end
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
            if (state_q != ST_LOAD) begin
                half_q <= 1'b0;
            end else if (tick) begin
                half_q <= ~half_q;
            end
        end
    end

    assign tick_en   = (state_q == ST_LOW) || (state_q == ST_HIGH) || (state_q == ST_LOAD);
    assign sh_ld     = (state_q == ST_GRAB);
    assign sh_shift  = (state_q == ST_HIGH) && tick && (bit_q != LAST_BIT);
    assign bit_phase = (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign busy      = (state_q != ST_IDLE);
    assign rom_addr  = addr_q;
    assign ctl       = ctl_q;

    // R1: the address is held while its byte is being captured
    a_r1_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GRAB) |-> $stable(addr_q));

    // R7: a start during a transfer never restarts addressing
    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && start && state_q != ST_HIGH) |=> $stable(addr_q));

    // R6: done lasts a single cycle and coincides with the idle state
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        ctl_q.done |=> !ctl_q.done);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
        ctl_q.done |-> !busy);

endmodule

// File: rtl/chanload_top.sv
module chanload_top
    import chanload_pkg::*;
#(
    parameter int HALF_DIV = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CHAN_W-1:0] chan,
    input  logic              tx_sel,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [BYTE_W-1:0] rom_data,
    output logic              busy,
    output logic              done,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_load
);
    logic     tick, tick_en, sh_ld, sh_shift, bit_phase, msb;
    ser_ctl_t ctl;

    chanload_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (tick_en),
        .tick (tick)
    );

    chanload_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .chan      (chan),
        .tx_sel    (tx_sel),
        .tick      (tick),
        .tick_en   (tick_en),
        .rom_addr  (rom_addr),
        .sh_ld     (sh_ld),
        .sh_shift  (sh_shift),
        .bit_phase (bit_phase),
        .busy      (busy),
        .ctl       (ctl)
    );

    chanload_shift #(.WIDTH(BYTE_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .ld    (sh_ld),
        .din   (rom_data),
        .shift (sh_shift),
        .msb   (msb)
    );

    assign ser_data = msb && bit_phase;
    assign ser_clk  = ctl.clk;
    assign ser_load = ctl.load;
    assign done     = ctl.done;

    // R3: data is steady through every high phase of the serial clock
    a_r3_data_steady: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R5: the serial clock rests low during the load strobe
    a_r5_load_clk_low: assert property (@(posedge clk) disable iff (rst)
        ser_load |-> !ser_clk);

endmodule

// File: tb/chanload_top_bench.sv
module chanload_top_bench;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  chan = '0;
    logic        tx_sel = 1'b0;
    logic [10:0] rom_addr;
    logic [7:0]  rom_data;
    logic        busy, done, ser_data, ser_clk, ser_load;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_q[$];
    logic [10:0] addr_q[$];

    always #5 clk = ~clk;

    chanload_top #(.HALF_DIV(HALF)) u_chanload_top (
        .clk(clk), .rst(rst), .start(start), .chan(chan), .tx_sel(tx_sel),
        .rom_addr(rom_addr), .rom_data(rom_data), .busy(busy), .done(done),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_load(ser_load)
    );

    function automatic logic [7:0] rom_byte(input logic [10:0] a);
        case (a)
            11'h004: return 8'h00;
            11'h005: return 8'h01;
            11'h006: return 8'h1E;
            11'h007: return 8'h10;
            11'h404: return 8'h00;
            11'h405: return 8'h01;
            11'h406: return 8'h1B;
            11'h407: return 8'h18;
            default: return 8'(a * 11'd37) ^ 8'(a >> 3) ^ 8'h5A;
        endcase
    endfunction

    always_ff @(posedge clk) rom_data <= rom_byte(rom_addr);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [7:0] c, input logic t);
        logic [10:0] base;
        base = (t ? 11'h400 : 11'h000) + {c, 2'b00};
        exp_q.push_back({rom_byte(base), rom_byte(base + 11'd1),
                         rom_byte(base + 11'd2), rom_byte(base + 11'd3)});
        for (int k = 0; k < 4; k++) addr_q.push_back(base + 11'(k));
        @(negedge clk);
        chan = c; tx_sel = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R6 busy after start", {31'd0, busy}, 32'd1);
    endtask

    task automatic poke_while_busy(input logic [7:0] c, input logic t);
        @(negedge clk);
        chan = c; tx_sel = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
        check(!busy && !done, "R7 no second transfer", {30'd0, busy, done}, 32'd0);
    endtask

    // monitor
    logic        p_clk = 1'b0, p_load = 1'b0, p_busy = 1'b0;
    logic [10:0] p_addr = '0;
    logic [31:0] acc = '0;
    logic [16:0] rcv = '0;
    int          nbits = 0, hi_len = 0, ld_len = 0, loads = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (busy && (!p_busy || rom_addr != p_addr)) begin
                if (addr_q.size() == 0) check(1'b0, "R1 unexpected address", 32'(rom_addr), 32'hFFFF);
                else begin
                    logic [10:0] ea;
                    ea = addr_q.pop_front();
                    check(rom_addr == ea, "R1 rom address", 32'(rom_addr), 32'(ea));
                end
            end
            if (ser_clk) hi_len++;
            if (ser_clk && !p_clk) begin
                acc = {acc[30:0], ser_data};
                rcv = {rcv[15:0], ser_data};
                nbits++;
            end
            if (!ser_clk && p_clk) begin
                check(hi_len == HALF, "R8 high phase width", 32'(hi_len), 32'(HALF));
                hi_len = 0;
            end
            if (ser_load) ld_len++;
            if (ser_load && !p_load) begin
                logic [31:0] e;
                loads++;
                check(nbits == 32, "R2 rising edge count", 32'(nbits), 32'd32);
                if (exp_q.size() == 0) check(1'b0, "R7 unexpected load", acc, 32'd0);
                else begin
                    e = exp_q.pop_front();
                    check(acc == e, "R2 serial entry order", acc, e);
                    check(rcv == e[16:0], "R4 receiver word", 32'(rcv), 32'(e[16:0]));
                end
            end
            if (!ser_load && p_load) begin
                check(ld_len == 2 * HALF, "R5 load width", 32'(ld_len), 32'(2 * HALF));
                check(done && !busy, "R6 done with load fall", {30'd0, done, busy}, 32'd2);
                ld_len = 0; nbits = 0;
            end
            if (done && !(!ser_load && p_load))
                check(1'b0, "R6 done misplaced", 32'd1, 32'd0);
        end
        p_clk = ser_clk; p_load = ser_load; p_busy = busy; p_addr = rom_addr;
    end

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                check(1'b0, "watchdog expired", 32'd1, 32'd0);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check({ser_clk, ser_data, ser_load, busy, done} == 5'b0, "R9 reset outputs",
              32'({ser_clk, ser_data, ser_load, busy, done}), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        launch(8'd1, 1'b0); wait_done();   // R4 receive channel 1 -> 0x11E10
        check(rcv == 17'h11E10, "R4 rx channel 1 word", 32'(rcv), 32'h11E10);
        launch(8'd1, 1'b1); wait_done();   // R4 transmit channel 1 -> 0x11B18
        check(rcv == 17'h11B18, "R4 tx channel 1 word", 32'(rcv), 32'h11B18);
        launch(8'd0, 1'b0); wait_done();   // R1 lowest entry
        launch(8'd255, 1'b1); wait_done(); // R1 top of transmit region
        launch(8'd255, 1'b0); wait_done();
        launch(8'd37, 1'b1); wait_done();

        // R7: start during a transfer is ignored
        launch(8'd9, 1'b0);
        repeat (20) @(negedge clk);
        poke_while_busy(8'd200, 1'b1);
        repeat (90) @(negedge clk);
        poke_while_busy(8'd3, 1'b1);
        wait_done();
        check(loads == 7, "R7 load count", 32'(loads), 32'd7);
        check(exp_q.size() == 0 && addr_q.size() == 0, "R1 queues drained",
              32'(exp_q.size() + addr_q.size()), 32'd0);

        // back to back: restart in the cycle after done
        launch(8'd2, 1'b1); wait_done();
        launch(8'd2, 1'b1); wait_done();

        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule